// File: doc/BRIEF.md
# Synthesizer Divider Configuration Interface

This block holds the divider settings of a clock synthesizer. It keeps three settings in holding registers: a 9-bit loop modulus M, a 2-bit output divider code N and a 3-bit test field. The loop and output dividers that sit next to it read these registers directly. The registers can be written over two independent paths. The first is a serial path: a data pin, a shift clock and a load strobe. The second is a parallel path: a load strobe and direct pins for M and N.

All inputs are taken as synchronous to the block clock `clk`. The serial shift clock is a sampled level. A shift happens once for each low-to-high change seen on it. The block also raises a flag whenever the held modulus lies outside the range in which the loop can lock.

Top module: `synth_div_cfg`

## Requirements
- R1: After reset the holding registers read M = 200 (binary 011001000), N code = 00 and test = 000, and the range flag is low.
- R2: On each `clk` edge where `ser_clk` is high and was low at the previous edge, the 14-bit shift chain moves by one place and takes in `ser_data`. Holding `ser_clk` high for several cycles gives only one shift. Shifting alone never changes the outputs.
- R3: The serial word is sent as 14 bits. The test field comes first, then N, then M, each field most significant bit first. A `clk` edge with `ser_load` high and `par_load` low copies the chain into all three registers, visible on the outputs after that edge.
- R4: A `clk` edge with `par_load` high copies `par_m` into M and `par_n` into N, and leaves the test field unchanged.
- R5: When `par_load` and `ser_load` are high at the same edge, the parallel values win for M and N, and the test field keeps its old value.
- R6: With both strobes low, M, N and the test field keep their values, whatever the data pins do.
- R7: `m_range_err` is high exactly when the held M is below 200 or above 400. It changes at the same edge as M. The bounds 200 and 400 themselves are in range.
- R8: M is plain binary (262 is 100000110). The N code is passed through unchanged: 00, 01, 10 and 11 select division by 2, 4, 8 and 16, so 01 means divide by 4. A serial load does not clear the chain, so a second `ser_load` with no shifting in between loads the same word again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, sampled; a rising change shifts once |
| ser_load | input | 1 | Copies the shift chain into the holding registers |
| par_load | input | 1 | Copies the parallel pins into M and N |
| par_m | input | 9 | Parallel loop modulus |
| par_n | input | 2 | Parallel output divider code |
| m_out | output | 9 | Held loop modulus |
| n_code | output | 2 | Held output divider code |
| test_bits | output | 3 | Held test field |
| m_range_err | output | 1 | High while held M is outside 200..400 |

## Verification
Two functions can fall in the same cycle: a serial load and a parallel load. The bench first shifts a full word into the chain that differs in every field from the pin values. It then raises both strobes for the same single cycle. It expects M and N to come from the pins and the test field to keep the value it had before. A later serial load with no new shifting must then bring back the chain word, which shows that the chain itself was left untouched.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;
  parameter int M_W     = 9;
  parameter int N_W     = 2;
  parameter int T_W     = 3;
  parameter int M_MIN   = 200;
  parameter int M_MAX   = 400;
  parameter int M_RESET = 200;
  localparam int CHAIN_W = T_W + N_W + M_W;
endpackage

// File: rtl/cfg_rst_sync.sv
`timescale 1ns/1ps
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb stage_d = {stage_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_s_n = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_edge_rise.sv
`timescale 1ns/1ps
module cfg_edge_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/cfg_shift_chain.sv
`timescale 1ns/1ps
module cfg_shift_chain #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] chain_q
);
  logic [W-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/cfg_field_latch.sv
`timescale 1ns/1ps
module cfg_field_latch #(
  parameter int W   = 9,
  parameter int RST = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_hi,
  input  logic [W-1:0] d_hi,
  input  logic         ld_lo,
  input  logic [W-1:0] d_lo,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  localparam logic [W-1:0] RST_V = W'(RST);

  always_comb begin
    q_nxt = q;
    if (ld_hi)      q_nxt = d_hi;
    else if (ld_lo) q_nxt = d_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_V;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/synth_div_cfg.sv
`timescale 1ns/1ps
module synth_div_cfg
  import synth_cfg_pkg::*;
#(
  parameter int MW = M_W,
  parameter int NW = N_W,
  parameter int TW = T_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_data,
  input  logic          ser_clk,
  input  logic          ser_load,
  input  logic          par_load,
  input  logic [MW-1:0] par_m,
  input  logic [NW-1:0] par_n,
  output logic [MW-1:0] m_out,
  output logic [NW-1:0] n_code,
  output logic [TW-1:0] test_bits,
  output logic          m_range_err
);
  localparam int CW = TW + NW + MW;
  localparam logic [MW-1:0] M_LO = MW'(M_MIN);
  localparam logic [MW-1:0] M_HI = MW'(M_MAX);

  logic          rst_s_n;
  logic          shift_en;
  logic [CW-1:0] chain_q;
  logic          ser_take;
  logic [MW-1:0] m_nxt;
  logic [NW-1:0] n_nxt;
  logic [TW-1:0] t_nxt;
  logic          err_d;
  logic          err_q;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  cfg_edge_rise u_edge (
    .clk(clk), .rst_n(rst_s_n), .level(ser_clk), .rise(shift_en)
  );

  cfg_shift_chain #(.W(CW)) u_chain (
    .clk(clk), .rst_n(rst_s_n), .shift_en(shift_en), .din(ser_data),
    .chain_q(chain_q)
  );

  // serial copy only when the parallel strobe is idle
  assign ser_take = ser_load & ~par_load;

  cfg_field_latch #(.W(MW), .RST(M_RESET)) u_m (
    .clk(clk), .rst_n(rst_s_n),
    .ld_hi(par_load), .d_hi(par_m),
    .ld_lo(ser_take), .d_lo(chain_q[MW-1:0]),
    .q(m_out), .q_nxt(m_nxt)
  );

  cfg_field_latch #(.W(NW), .RST(0)) u_n (
    .clk(clk), .rst_n(rst_s_n),
    .ld_hi(par_load), .d_hi(par_n),
    .ld_lo(ser_take), .d_lo(chain_q[MW+NW-1:MW]),
    .q(n_code), .q_nxt(n_nxt)
  );

  cfg_field_latch #(.W(TW), .RST(0)) u_t (
    .clk(clk), .rst_n(rst_s_n),
    .ld_hi(1'b0), .d_hi({TW{1'b0}}),
    .ld_lo(ser_take), .d_lo(chain_q[CW-1:MW+NW]),
    .q(test_bits), .q_nxt(t_nxt)
  );

  // flag registered from the next modulus so it moves with m_out
  always_comb err_d = (m_nxt < M_LO) || (m_nxt > M_HI);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign m_range_err = err_q;
endmodule

// File: rtl/synth_div_cfg_chk.sv
`timescale 1ns/1ps
module synth_div_cfg_chk #(
  parameter int MW = 9,
  parameter int NW = 2,
  parameter int TW = 3,
  parameter int LO = 200,
  parameter int HI = 400
) (
  input logic                clk,
  input logic                rst_s_n,
  input logic                ser_load,
  input logic                par_load,
  input logic [MW-1:0]       par_m,
  input logic [NW-1:0]       par_n,
  input logic [TW+NW+MW-1:0] chain_q,
  input logic [MW-1:0]       m_out,
  input logic [NW-1:0]       n_code,
  input logic [TW-1:0]       test_bits,
  input logic                m_range_err
);
  a_r4_par_capture: assert property (@(posedge clk) disable iff (!rst_s_n)
    par_load |=> (m_out == $past(par_m)) && (n_code == $past(par_n)));

  a_r5_test_kept: assert property (@(posedge clk) disable iff (!rst_s_n)
    par_load |=> $stable(test_bits));

  a_r3_ser_copy: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ser_load && !par_load) |=> ({test_bits, n_code, m_out} == $past(chain_q)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ser_load && !par_load) |=> $stable(m_out) && $stable(n_code) && $stable(test_bits));

  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    m_range_err == ((int'(m_out) < LO) || (int'(m_out) > HI)));
endmodule

bind synth_div_cfg synth_div_cfg_chk #(
  .MW(MW), .NW(NW), .TW(TW),
  .LO(synth_cfg_pkg::M_MIN), .HI(synth_cfg_pkg::M_MAX)
) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .ser_load(ser_load), .par_load(par_load),
  .par_m(par_m), .par_n(par_n), .chain_q(chain_q), .m_out(m_out),
  .n_code(n_code), .test_bits(test_bits), .m_range_err(m_range_err)
);

// File: tb/sim_synth_div_cfg.sv
`timescale 1ns/1ps
module sim_synth_div_cfg;
  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    logic       err;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_data, ser_clk, ser_load, par_load;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic [8:0] m_out;
  logic [1:0] n_code;
  logic [2:0] test_bits;
  logic       m_range_err;

  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  synth_div_cfg u0 (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
    .m_out(m_out), .n_code(n_code), .test_bits(test_bits),
    .m_range_err(m_range_err)
  );

  function automatic void push_exp(logic [8:0] m, logic [1:0] n, logic [2:0] t, string tag);
    exp_t e;
    e.m = m; e.n = n; e.t = t;
    e.err = (m < 9'd200) || (m > 9'd400);
    e.tag = tag;
    sb_q.push_back(e);
  endfunction

  // monitor: compare mid-high phase, away from both edges
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (m_out !== e.m || n_code !== e.n || test_bits !== e.t || m_range_err !== e.err) begin
          fails++;
          $display("FAIL %s: got m=%0d n=%b t=%b err=%b, expected m=%0d n=%b t=%b err=%b",
                   e.tag, m_out, n_code, test_bits, m_range_err, e.m, e.n, e.t, e.err);
        end
      end
    end
  end

  task automatic ser_bit(input logic b, input int hold);
    @(negedge clk);
    ser_data = b;
    ser_clk  = 1'b1;
    repeat (hold) @(negedge clk);
    ser_clk  = 1'b0;
  endtask

  task automatic ser_word(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m, input int long_pos);
    logic [13:0] w;
    w = {t, n, m};
    for (int i = 13; i >= 0; i--) ser_bit(w[i], (i == long_pos) ? 3 : 1);
    @(negedge clk);
  endtask

  task automatic strobe(input logic sl, input logic pl, input logic [8:0] m, input logic [1:0] n);
    @(negedge clk);
    ser_load = sl; par_load = pl; par_m = m; par_n = n;
    @(negedge clk);
    ser_load = 1'b0; par_load = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ser_data = 1'b0; ser_clk = 1'b0;
    ser_load = 1'b0; par_load = 1'b0; par_m = '0; par_n = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push_exp(9'd200, 2'b00, 3'b000, "R1 reset state");
    @(negedge clk);

    // R2 R3 R8: serial word t=101 n=01 (div4) m=262
    ser_word(3'b101, 2'b01, 9'd262, -1);
    push_exp(9'd200, 2'b00, 3'b000, "R2 shift alone leaves outputs");
    strobe(1'b1, 1'b0, '0, '0);
    push_exp(9'd262, 2'b01, 3'b101, "R3 R8 serial load 262 div4");
    @(negedge clk);

    // R2: long-high ser_clk counts once
    ser_word(3'b010, 2'b11, 9'd150, 6);
    strobe(1'b1, 1'b0, '0, '0);
    push_exp(9'd150, 2'b11, 3'b010, "R2 R7 one shift per rise, low M flagged");
    @(negedge clk);

    // R4 R7 bounds
    strobe(1'b0, 1'b1, 9'd400, 2'b10);
    push_exp(9'd400, 2'b10, 3'b010, "R4 R7 parallel 400 in range");
    @(negedge clk);
    strobe(1'b0, 1'b1, 9'd401, 2'b01);
    push_exp(9'd401, 2'b01, 3'b010, "R7 401 flagged");
    @(negedge clk);
    strobe(1'b0, 1'b1, 9'd199, 2'b00);
    push_exp(9'd199, 2'b00, 3'b010, "R7 199 flagged");
    @(negedge clk);
    strobe(1'b0, 1'b1, 9'd200, 2'b11);
    push_exp(9'd200, 2'b11, 3'b010, "R7 200 in range");
    @(negedge clk);
    strobe(1'b0, 1'b1, 9'd511, 2'b01);
    push_exp(9'd511, 2'b01, 3'b010, "R4 R7 max code flagged");
    @(negedge clk);

    // R5: both strobes, chain holds t=010 n=11 m=150
    strobe(1'b1, 1'b1, 9'd300, 2'b00);
    push_exp(9'd300, 2'b00, 3'b010, "R5 parallel wins, test kept");
    @(negedge clk);

    // R6: pins wiggle, ser_clk idle, no strobes
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      par_m = 9'(37 * k + 11); par_n = 2'(k); ser_data = k[0];
    end
    @(negedge clk);
    push_exp(9'd300, 2'b00, 3'b010, "R6 hold with no strobe");
    @(negedge clk);

    // R8: reload same chain word
    strobe(1'b1, 1'b0, '0, '0);
    push_exp(9'd150, 2'b11, 3'b010, "R8 chain kept after load");
    @(negedge clk);

    // R3: different full serial word
    ser_word(3'b111, 2'b10, 9'd333, -1);
    strobe(1'b1, 1'b0, '0, '0);
    push_exp(9'd333, 2'b10, 3'b111, "R3 serial 333 field order");
    @(negedge clk);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule